// File: doc/BRIEF.md
# Single-Channel DMA Control and Status Unit

This block holds the register-side state of one DMA channel in a bridge between a peripheral and memory. Software sees four 32-bit registers: a condition register that mixes a fixed revision code, live and sticky status flags and control fields, a current-address register, a down-counting byte counter and a scratch test register. The data mover, its FIFO and burst logic sit outside. They report each moved byte on a one-cycle `xfer_done` strobe and each bus fault on `err_in`. They receive engine enable, direction, device reset and a FIFO flush pulse from this unit.

The byte counter counts down once per accepted byte when byte-count mode is on. Reaching zero sets a sticky terminal-count flag. That flag can raise the interrupt line unless its own disable bit is set, and this disable is separate from the global interrupt enable. A one-deep address queue lets software post the following buffer's address in advance. At terminal count in chaining mode, the queued address becomes the current one without software help. Holding the device-reset control bit wipes all status, empties the address queue, zeroes the counter and keeps the engine off.

Top module: `dma_ctl_unit`

## Requirements
- R1: Bits 31:28 of the condition register (register select 0) always read the parameter `VER_ID` (default 4'hA); writes to those bits have no effect.
- R2: After `rst_n` is low, every register reads zero apart from the revision nibble, and `irq`, `dev_rst`, `eng_on`, `to_mem` and `dma_addr` are low.
- R3: Condition bits 4 (interrupt enable), 7 (device reset), 8 (direction, 1 = device to memory), 9 (engine enable), 13 (byte-count mode), 16, 17, 18-19, 20, 21, 22, 23 (terminal-count interrupt disable), 24 (chaining) and 25 are read/write. Bits 3:2 read the `drain` input and bit 10 reads `rd_pend`. Writing 1 to bit 5 gives a `fifo_flush` pulse in the same cycle, and bit 5 always reads 0. Bit 7 drives `dev_rst`, bit 8 drives `to_mem` and bit 9 drives `eng_on`.
- R4: A write to the counter (register select 2) keeps only the low 24 bits. Bits 31:24 always read 0.
- R5: On a clock edge where `xfer_done` is high, bits 9 and 13 are set and the counter is nonzero, the counter drops by one. At zero it stays at zero. A counter write in the same cycle wins over the decrement.
- R6: A decrement from 1 to 0 sets the sticky terminal-count flag, which reads at bit 14.
- R7: Bit 0 reads `err | (tc & ~bit23)`. `irq` equals bit 4 AND bit 0.
- R8: Writing the condition register with bit 0 set clears the error and terminal-count flags. A flag-setting event in the same cycle wins.
- R9: `err_in` high at a clock edge sets the sticky error flag at bit 1.
- R10: A write to the address register (select 1) loads the current address and sets the address-loaded flag (bit 26). When chaining is on and an address is already loaded, the write goes to the queued slot instead and sets the next-loaded flag (bit 27).
- R11: At terminal count with chaining on and bit 27 set, the queued address becomes the current address and bit 27 clears. An address write in the same cycle refills the queue.
- R12: The current address (read at select 1 and on `dma_addr`) increments once per `xfer_done` accepted while bit 9 is set. A chaining swap in the same cycle takes precedence, and an address write that loads the current address overrides both.
- R13: While bit 7 is held, each clock edge clears the error, terminal-count and both loaded flags, zeroes the counter and forces bit 9 to 0.
- R14: The test register (select 3) stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 condition, 1 address, 2 counter, 3 test |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| xfer_done | input | 1 | One byte moved by the data mover |
| err_in | input | 1 | Bus error reported by the data mover |
| drain | input | 2 | Live FIFO drain status |
| rd_pend | input | 1 | Live read-pending status |
| irq | output | 1 | Interrupt request |
| dev_rst | output | 1 | Reset to the attached device |
| eng_on | output | 1 | Engine enable |
| to_mem | output | 1 | Direction, 1 = device to memory |
| fifo_flush | output | 1 | One-cycle FIFO invalidate pulse |
| dma_addr | output | 32 | Current transfer address |

## Verification
The hard overlap is a terminal-count swap of the queued address and a software write to the address register at the same clock edge. The queued address must reach the current slot and the new write must stay queued for the next terminal count. The bench forces this with a one-byte count and an address write on the same edge as the last `xfer_done`. It then runs a second terminal count to expose the queued value. Two more collisions are made both by hand and by the random phase: an acknowledge against a new error, and a counter load against a decrement. After each edge the bench's own model predicts all four registers and judges them.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int DW = 32;

  // condition-register bit positions (software-visible layout)
  localparam int B_REQ   = 0;
  localparam int B_ERR   = 1;
  localparam int B_DRN   = 2;
  localparam int B_IE    = 4;
  localparam int B_FLUSH = 5;
  localparam int B_DRST  = 7;
  localparam int B_DIR   = 8;
  localparam int B_EN    = 9;
  localparam int B_RDP   = 10;
  localparam int B_BCNT  = 13;
  localparam int B_TC    = 14;
  localparam int B_CDIS  = 23;
  localparam int B_AUTO  = 24;
  localparam int B_ALD   = 26;
  localparam int B_NLD   = 27;
  localparam int B_ID    = 28;

  // bits that software may write and read back unchanged
  localparam logic [DW-1:0] CTL_MASK = 32'h03FF_2390;

  typedef enum logic [1:0] {
    RS_COND = 2'd0,
    RS_ADDR = 2'd1,
    RS_CNT  = 2'd2,
    RS_TEST = 2'd3
  } reg_sel_e;

  function automatic logic irq_request(input logic err, input logic tc, input logic cdis);
    return err | (tc & ~cdis);
  endfunction
endpackage

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          tc_evt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] count_down(input logic [CW-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  logic live_step;
  assign live_step = step & ~load & ~hold_clr;
  assign tc_evt    = live_step & (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (hold_clr) cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (step)     cnt <= count_down(cnt);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (live_step && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R5
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0)); // R5
endmodule

// File: rtl/dma_addr_queue.sv
module dma_addr_queue #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_clr,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  input  logic          chain_on,
  input  logic          tc_evt,
  input  logic          adv,
  output logic [AW-1:0] cur,
  output logic          cur_ld,
  output logic          nxt_ld
);
  logic [AW-1:0] nxt;
  logic          swap;
  logic          to_next;

  assign swap    = tc_evt & chain_on & nxt_ld;
  assign to_next = chain_on & cur_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      nxt    <= '0;
      cur_ld <= 1'b0;
      nxt_ld <= 1'b0;
    end else begin
      if (swap) begin
        cur    <= nxt;
        nxt_ld <= 1'b0;
      end else if (adv) begin
        cur <= cur + AW'(1);
      end
      if (wr) begin
        if (to_next) begin
          nxt    <= wdata;
          nxt_ld <= 1'b1;
        end else begin
          cur    <= wdata;
          cur_ld <= 1'b1;
        end
      end
      if (hold_clr) begin
        cur_ld <= 1'b0;
        nxt_ld <= 1'b0;
      end
    end
  end

  AST_CHAIN_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !(wr && !to_next)) |=> (cur == $past(nxt))); // R11
  AST_QUEUE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_ld |-> cur_ld); // R10
endmodule

// File: rtl/dma_cond_reg.sv
module dma_cond_reg
  import dma_ctl_pkg::*;
#(
  parameter logic [3:0] VER_ID = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          err_evt,
  input  logic          tc_evt,
  input  logic [1:0]    drain,
  input  logic          rd_pend,
  input  logic          cur_ld,
  input  logic          nxt_ld,
  output logic [DW-1:0] ctl,
  output logic          err,
  output logic          tc,
  output logic [DW-1:0] cond_val,
  output logic          irq
);
  logic          ack;
  logic          hold;
  logic          req;
  logic [DW-1:0] ctl_nx;

  assign ack  = wr & wdata[B_REQ];
  assign hold = ctl[B_DRST];
  assign req  = irq_request(err, tc, ctl[B_CDIS]);
  assign irq  = ctl[B_IE] & req;

  always_comb begin
    ctl_nx = wr ? (wdata & CTL_MASK) : ctl;
    if (hold) ctl_nx[B_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      err <= 1'b0;
      tc  <= 1'b0;
    end else begin
      ctl <= ctl_nx;
      err <= hold ? 1'b0 : (err_evt | (err & ~ack));
      tc  <= hold ? 1'b0 : (tc_evt  | (tc  & ~ack));
    end
  end

  always_comb begin
    cond_val                   = ctl;
    cond_val[B_ID +: 4]        = VER_ID;
    cond_val[B_NLD]            = nxt_ld;
    cond_val[B_ALD]            = cur_ld;
    cond_val[B_TC]             = tc;
    cond_val[B_RDP]            = rd_pend;
    cond_val[B_DRN +: 2]       = drain;
    cond_val[B_ERR]            = err;
    cond_val[B_REQ]            = req;
  end

  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && !hold) |=> tc); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err_evt && !tc_evt) |=> (!err && !tc)); // R8
  AST_HOLD_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!err && !tc && !ctl[B_EN])); // R13
endmodule

// File: rtl/dma_ctl_unit.sv
module dma_ctl_unit
  import dma_ctl_pkg::*;
#(
  parameter logic [3:0] VER_ID = 4'hA,
  parameter int         CNT_W  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        xfer_done,
  input  logic        err_in,
  input  logic [1:0]  drain,
  input  logic        rd_pend,
  output logic        irq,
  output logic        dev_rst,
  output logic        eng_on,
  output logic        to_mem,
  output logic        fifo_flush,
  output logic [31:0] dma_addr
);
  logic [DW-1:0]    ctl;
  logic [DW-1:0]    cond_val;
  logic [DW-1:0]    test_q;
  logic [CNT_W-1:0] cnt;
  logic             err, tc, tc_evt;
  logic             cur_ld, nxt_ld;
  logic             wr_cond, wr_addr, wr_cnt, wr_test;
  logic             accepted, cnt_step;

  assign wr_cond = reg_wr & (reg_sel == RS_COND);
  assign wr_addr = reg_wr & (reg_sel == RS_ADDR);
  assign wr_cnt  = reg_wr & (reg_sel == RS_CNT);
  assign wr_test = reg_wr & (reg_sel == RS_TEST);

  assign accepted = xfer_done & ctl[B_EN];
  assign cnt_step = accepted & ctl[B_BCNT];

  assign dev_rst    = ctl[B_DRST];
  assign eng_on     = ctl[B_EN];
  assign to_mem     = ctl[B_DIR];
  assign fifo_flush = wr_cond & reg_wdata[B_FLUSH];

  dma_cond_reg #(.VER_ID(VER_ID)) u_cond (
    .clk(clk), .rst_n(rst_n), .wr(wr_cond), .wdata(reg_wdata),
    .err_evt(err_in), .tc_evt(tc_evt), .drain(drain), .rd_pend(rd_pend),
    .cur_ld(cur_ld), .nxt_ld(nxt_ld), .ctl(ctl), .err(err), .tc(tc),
    .cond_val(cond_val), .irq(irq)
  );

  dma_byte_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold_clr(ctl[B_DRST]), .load(wr_cnt),
    .load_val(reg_wdata[CNT_W-1:0]), .step(cnt_step), .cnt(cnt), .tc_evt(tc_evt)
  );

  dma_addr_queue #(.AW(DW)) u_addr (
    .clk(clk), .rst_n(rst_n), .hold_clr(ctl[B_DRST]), .wr(wr_addr),
    .wdata(reg_wdata), .chain_on(ctl[B_AUTO]), .tc_evt(tc_evt), .adv(accepted),
    .cur(dma_addr), .cur_ld(cur_ld), .nxt_ld(nxt_ld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       test_q <= '0;
    else if (wr_test) test_q <= reg_wdata;
  end

  always_comb begin
    unique case (reg_sel)
      RS_COND: reg_rdata = cond_val;
      RS_ADDR: reg_rdata = dma_addr;
      RS_CNT:  reg_rdata = DW'(cnt);
      default: reg_rdata = test_q;
    endcase
  end

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl[B_IE]); // R7
  AST_ENG_OFF_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dev_rst) |-> !eng_on); // R13
endmodule

// File: tb/dma_ctl_unit_tb_top.sv
`timescale 1ns/100ps
module dma_ctl_unit_tb_top;
  localparam logic [3:0]  VID  = 4'hA;
  localparam logic [31:0] RWM  = 32'h03FF_2390;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_done = 1'b0, err_in = 1'b0, rd_pend = 1'b0;
  logic [1:0]  drain = 2'd0;
  logic        irq, dev_rst, eng_on, to_mem, fifo_flush;
  logic [31:0] dma_addr;

  int n_vec = 0;
  int n_bad = 0;

  // bench model
  logic [31:0] m_ctl = '0, m_cur = '0, m_nxt = '0, m_test = '0;
  logic [23:0] m_cnt = '0;
  logic        m_err = 0, m_tc = 0, m_ald = 0, m_nld = 0;

  always #2.5 clk = ~clk;

  dma_ctl_unit #(.VER_ID(VID)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .err_in(err_in), .drain(drain), .rd_pend(rd_pend), .irq(irq),
    .dev_rst(dev_rst), .eng_on(eng_on), .to_mem(to_mem),
    .fifo_flush(fifo_flush), .dma_addr(dma_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cond();
    logic [31:0] e;
    logic        pend;
    pend = m_err || (m_tc && !m_ctl[23]);
    e = m_ctl & RWM;
    e[31:28] = VID;
    e[27] = m_nld; e[26] = m_ald; e[14] = m_tc; e[10] = rd_pend;
    e[3:2] = drain; e[1] = m_err; e[0] = pend;
    return e;
  endfunction

  // next-state of the model at a clock edge, from current model + inputs
  task automatic model_edge();
    logic hold, acc, dec, tce, swp, wc, wa, wn, wt, ack;
    hold = m_ctl[7];
    wc = reg_wr && reg_sel == 2'd0; wa = reg_wr && reg_sel == 2'd1;
    wn = reg_wr && reg_sel == 2'd2; wt = reg_wr && reg_sel == 2'd3;
    ack = wc && reg_wdata[0];
    acc = xfer_done && m_ctl[9];
    dec = acc && m_ctl[13] && m_cnt != 0;
    tce = !hold && !wn && dec && m_cnt == 24'd1;
    swp = tce && m_ctl[24] && m_nld;
    if (swp) begin m_cur = m_nxt; m_nld = 0; end
    else if (acc) m_cur = m_cur + 1;
    if (wa) begin
      if (m_ctl[24] && m_ald) begin m_nxt = reg_wdata; m_nld = 1; end
      else begin m_cur = reg_wdata; m_ald = 1; end
    end
    if (hold) begin m_ald = 0; m_nld = 0; end
    if (hold) m_cnt = '0; else if (wn) m_cnt = reg_wdata[23:0]; else if (dec) m_cnt = m_cnt - 1;
    m_err = hold ? 1'b0 : (err_in || (m_err && !ack));
    m_tc  = hold ? 1'b0 : (tce || (m_tc && !ack));
    if (wc) m_ctl = reg_wdata & RWM;
    if (hold) m_ctl[9] = 1'b0;
    if (wt) m_test = reg_wdata;
  endtask

  task automatic check_all(input string ctx);
    reg_sel = 2'd0; #0.2 chk({ctx, " R1 R3 R6 R7 R9 R10 cond"}, reg_rdata, exp_cond());
    reg_sel = 2'd1; #0.2 chk({ctx, " R10 R11 R12 addr"}, reg_rdata, m_cur);
    reg_sel = 2'd2; #0.2 chk({ctx, " R4 R5 R13 count"}, reg_rdata, {8'h0, m_cnt});
    reg_sel = 2'd3; #0.2 chk({ctx, " R14 test"}, reg_rdata, m_test);
    chk({ctx, " R7 irq"}, {31'h0, irq}, {31'h0, m_ctl[4] & exp_cond()[0]});
    chk({ctx, " R3 pins"}, {29'h0, dev_rst, eng_on, to_mem}, {29'h0, m_ctl[7], m_ctl[9], m_ctl[8]});
    chk({ctx, " R12 dma_addr"}, dma_addr, m_cur);
  endtask

  // one clock: drive at the current (falling-edge) time, apply, check
  task automatic cyc(input string ctx, input logic w, input logic [1:0] s,
                     input logic [31:0] d, input logic xd, input logic ei);
    reg_wr = w; reg_sel = s; reg_wdata = d; xfer_done = xd; err_in = ei;
    #0.2 chk({ctx, " R3 flush"}, {31'h0, fifo_flush}, {31'h0, w && s == 2'd0 && d[5]});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    reg_wr = 0; xfer_done = 0; err_in = 0; reg_wdata = '0;
    check_all(ctx);
  endtask

  localparam logic [31:0] C_RUN = 32'h0100_2210; // IE, EN, BCNT, AUTO

  initial begin : watchdog
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0D3A));
    repeat (3) @(negedge clk);
    check_all("R2 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: revision nibble ignores writes; R3: flush pulse, bit5 reads 0
    cyc("R1 id write", 1, 2'd0, 32'hF000_0020, 0, 0);
    cyc("R3 run ctl", 1, 2'd0, C_RUN | 32'h100, 0, 0);
    // R10: first address loads current, second is queued
    cyc("R10 cur", 1, 2'd1, 32'h0000_1000, 0, 0);
    cyc("R10 nxt", 1, 2'd1, 32'h0000_2000, 0, 0);
    // R4: upper count bits dropped
    cyc("R4 count", 1, 2'd2, 32'hAB00_0003, 0, 0);
    // R5 R12: bytes move; R6 R11 R7 on the last one
    cyc("R5 byte1", 0, 2'd0, 0, 1, 0);
    cyc("R5 byte2", 0, 2'd0, 0, 1, 0);
    cyc("R6 R11 tc", 0, 2'd0, 0, 1, 0);
    cyc("R5 floor", 0, 2'd0, 0, 1, 0);
    // R8: acknowledge
    cyc("R8 ack", 1, 2'd0, C_RUN | 32'h1, 0, 0);
    // R9: error, then ack colliding with a new error keeps it
    cyc("R9 err", 0, 2'd0, 0, 0, 1);
    cyc("R8 ack vs err", 1, 2'd0, C_RUN | 32'h1, 0, 1);
    cyc("R8 ack", 1, 2'd0, C_RUN | 32'h1, 0, 0);
    // R7: terminal count with its own interrupt disabled
    cyc("R7 cdis ctl", 1, 2'd0, C_RUN | 32'h0080_0000, 0, 0);
    cyc("R7 cnt1", 1, 2'd2, 32'h1, 0, 0);
    cyc("R7 tc masked", 0, 2'd0, 0, 1, 0);
    cyc("R8 ack", 1, 2'd0, C_RUN | 32'h1, 0, 0);
    // R5: counter load collides with a decrement
    cyc("R5 load", 1, 2'd2, 32'h5, 0, 0);
    cyc("R5 load vs dec", 1, 2'd2, 32'h9, 1, 0);
    // R11: swap and address write on the same edge
    cyc("R11 q", 1, 2'd1, 32'h0000_3000, 0, 0);
    cyc("R11 cnt1", 1, 2'd2, 32'h1, 0, 0);
    cyc("R11 swap+wr", 1, 2'd1, 32'h0000_4000, 1, 0);
    cyc("R11 cnt1b", 1, 2'd2, 32'h1, 0, 0);
    cyc("R11 swap2", 0, 2'd0, 0, 1, 0);
    // R14: test register
    cyc("R14 test", 1, 2'd3, 32'hDEAD_BEEF, 0, 0);
    // R13: device reset hold
    cyc("R13 hold on", 1, 2'd0, C_RUN | 32'h80, 0, 1);
    cyc("R13 held", 0, 2'd0, 0, 1, 0);
    cyc("R13 release", 1, 2'd0, C_RUN, 0, 0);
    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      logic        w;
      logic [1:0]  s;
      logic [31:0] d;
      drain   = 2'($urandom % 4);
      rd_pend = 1'($urandom % 2);
      w = ($urandom % 4) == 0;
      s = 2'($urandom % 4);
      d = $urandom;
      if (s == 2'd0) begin
        d[7] = ($urandom % 16) == 0;
        if (($urandom % 4) != 0) d = d | 32'h0000_2200;
        d[0] = ($urandom % 3) == 0;
      end else if (s == 2'd2) begin
        d = $urandom % 6;
      end
      cyc("rnd", w, s, d, 1'($urandom % 2), ($urandom % 23) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule